// File: doc/BRIEF.md
# Calendar Clock Timer with Alarm

This block keeps time of day and a running day count from a 256 Hz timing pulse. An 8-bit prescaler splits each second into 256 steps and exposes binary taps from 128 Hz down to 1 Hz. Its overflow drives a chain of counters for seconds, minutes, hours and a 16-bit day count. A run bit gates the whole chain. While the chain is stopped, every counter keeps its value, so time resumes exactly where it paused.

Software uses a single-cycle register bus. A write takes effect at the clock edge where `bus_we` is high. A read is combinational from `bus_addr`. There is no handshake and no back-pressure: every access completes in the cycle it is presented.

The block raises two requests, a periodic one and an alarm. The periodic request follows a selected prescaler tap or a calendar rollover. The alarm follows a match between the calendar and the compare registers. Each request is a sticky flag that software clears by writing 1 to its bit.

Top module: `cal_clock_timer`

## Requirements
- R1: Writing bit0=1 at address 0x0 enables counting on each cycle where `tick_256hz` is high. Writing bit0=0 stops counting. While stopped, the prescaler and all counters hold their values, and counting resumes from them when run is set again.
- R2: The 8-bit prescaler (address 0x3) advances once per enabled tick. Its wrap from 255 to 0 advances the seconds counter by one.
- R3: Seconds and minutes count 0..59 and hours count 0..23. Each returns to 0 and carries into the next counter. The 16-bit day counter wraps from 65535 to 0.
- R4: Writes to the prescaler and seconds counter (0x3, 0x4) have no effect. Writes to minutes (0x5), hours (0x6), day low byte (0x7) and day high byte (0x8) load the value. A write to one counter leaves all lower counters undisturbed.
- R5: Seconds and minutes are 6 bits wide and hours is 5 bits wide. Bits above these widths read as 0 and are dropped on write.
- R6: The compare registers are readable and writable: minute (0x9, 6 bits), hour (0xA, 5 bits) and day (0xB, 5 bits). The day compare is matched against day[4:0] only.
- R7: The alarm select is at 0x1 bits[4:3]: 00 none, 01 minute, 10 minute and hour, 11 minute, hour and day. When alarm enable (0x1 bit6) is set, the alarm flag sets one cycle after the selected match becomes true. It sets once per rising match, never while the select is 00.
- R8: The periodic select is at 0x1 bits[2:0]: 000 32 Hz, 001 8 Hz, 010 2 Hz, 011 1 Hz, 100 minute, 101 hour, 110 day, 111 none. The periodic flag sets at the edge of the tick where the selected tap falls from 1 to 0, or where the selected calendar unit rolls over.
- R9: With periodic enable (0x1 bit5) clear, the periodic flag never sets.
- R10: Status at 0x2 holds the periodic flag in bit0 and the alarm flag in bit1. `periodic_irq` and `alarm_irq` show these flags. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R11: A counter write in the same cycle as an incoming carry wins. The written value is loaded, and that counter passes no carry onward.
- R12: Reset clears the flags, both enables, the prescaler and the seconds counter. Run, selects, minutes, hours, day and compare registers are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_256hz | input | 1 | Timing pulse; one prescaler step per high cycle |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| periodic_irq | output | 1 | Periodic request (sticky flag) |
| alarm_irq | output | 1 | Alarm request (sticky flag) |

## Verification
The assertions assume that reset is applied before the flags are trusted. They also assume that any register without reset has been written before its value matters. Finally, they assume the bus presents at most one write per cycle, with data stable across the edge.

The stimulus writes run, the selects, the calendar and the compare registers before each test depends on them. It changes inputs only at falling clock edges. It derives tick counts from values read back over the bus, so each rollover lands on a known cycle.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int DIV_W    = 8;
  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HOUR_W   = 5;
  localparam int DAY_W    = 16;
  localparam int DAYCMP_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] A_CFG   = 4'h1;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'h2;
  localparam logic [ADDR_W-1:0] A_DIV   = 4'h3;
  localparam logic [ADDR_W-1:0] A_SEC   = 4'h4;
  localparam logic [ADDR_W-1:0] A_MIN   = 4'h5;
  localparam logic [ADDR_W-1:0] A_HOUR  = 4'h6;
  localparam logic [ADDR_W-1:0] A_DLO   = 4'h7;
  localparam logic [ADDR_W-1:0] A_DHI   = 4'h8;
  localparam logic [ADDR_W-1:0] A_CMIN  = 4'h9;
  localparam logic [ADDR_W-1:0] A_CHOUR = 4'hA;
  localparam logic [ADDR_W-1:0] A_CDAY  = 4'hB;

  typedef enum logic [2:0] {
    PS_32HZ = 3'b000, PS_8HZ = 3'b001, PS_2HZ = 3'b010, PS_1HZ = 3'b011,
    PS_MIN  = 3'b100, PS_HOUR = 3'b101, PS_DAY = 3'b110, PS_NONE = 3'b111
  } psel_e;

  typedef enum logic [1:0] {
    AS_NONE = 2'b00, AS_MIN = 2'b01, AS_MIN_HOUR = 2'b10, AS_FULL = 2'b11
  } asel_e;
endpackage

// File: rtl/ctmr_prescaler.sv
module ctmr_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] cnt,
  output logic [W-1:0] fall,
  output logic         carry
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (adv) cnt <= cnt + W'(1);
  end

  // tap k falls when bits k..0 are all ones on an advancing step
  for (genvar k = 0; k < W; k++) begin : g_tap
    assign fall[k] = adv & (&cnt[k:0]);
  end

  assign carry = fall[W-1];

  // R1
  presc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt));
  // R2
  presc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> cnt == '0);
endmodule

// File: rtl/ctmr_unit_cnt.sv
module ctmr_unit_cnt #(
  parameter int           W       = 6,
  parameter logic [W-1:0] LAST    = '1,
  parameter bit           HAS_RST = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] val,
  output logic         carry
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = val;
    if (ld)       nxt = ld_val;
    else if (adv) nxt = (val >= LAST) ? '0 : val + W'(1);
  end

  if (HAS_RST) begin : g_rst
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val <= '0;
      else        val <= nxt;
    end
  end else begin : g_norst
    always_ff @(posedge clk) val <= nxt;
  end

  assign carry = adv & ~ld & (val >= LAST);

  // R3
  unit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && val >= LAST) |=> val == '0);
  // R11
  unit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> val == $past(ld_val));
  // R1
  unit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !ld) |=> $stable(val));
endmodule

// File: rtl/ctmr_irq.sv
module ctmr_irq
  import ctmr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  psel_e               p_sel,
  input  asel_e               a_sel,
  input  logic                p_en,
  input  logic                a_en,
  input  logic [DIV_W-1:0]    tap_fall,
  input  logic                min_evt,
  input  logic                hour_evt,
  input  logic                day_evt,
  input  logic [MIN_W-1:0]    cur_min,
  input  logic [HOUR_W-1:0]   cur_hour,
  input  logic [DAYCMP_W-1:0] cur_day,
  input  logic [MIN_W-1:0]    cmp_min,
  input  logic [HOUR_W-1:0]   cmp_hour,
  input  logic [DAYCMP_W-1:0] cmp_day,
  input  logic [1:0]          clr,
  output logic                p_flag,
  output logic                a_flag
);
  logic [2:0] tap_idx;
  logic       p_evt, p_hit;
  logic       a_match, a_match_q, a_hit;

  // prescaler taps 2,4,6 for selects 0..2, tap 7 for 1 Hz
  assign tap_idx = (p_sel == PS_1HZ) ? 3'd7 : {p_sel[1:0], 1'b0} + 3'd2;

  always_comb begin
    case (p_sel)
      PS_MIN:  p_evt = min_evt;
      PS_HOUR: p_evt = hour_evt;
      PS_DAY:  p_evt = day_evt;
      PS_NONE: p_evt = 1'b0;
      default: p_evt = tap_fall[tap_idx];
    endcase
  end

  assign p_hit = p_en & p_evt;

  always_comb begin
    case (a_sel)
      AS_MIN:      a_match = (cur_min == cmp_min);
      AS_MIN_HOUR: a_match = (cur_min == cmp_min) && (cur_hour == cmp_hour);
      AS_FULL:     a_match = (cur_min == cmp_min) && (cur_hour == cmp_hour)
                             && (cur_day == cmp_day);
      default:     a_match = 1'b0;
    endcase
  end

  assign a_hit = a_en & a_match & ~a_match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_flag    <= 1'b0;
      a_flag    <= 1'b0;
      a_match_q <= 1'b0;
    end else begin
      a_match_q <= a_match;
      if (p_hit)       p_flag <= 1'b1;
      else if (clr[0]) p_flag <= 1'b0;
      if (a_hit)       a_flag <= 1'b1;
      else if (clr[1]) a_flag <= 1'b0;
    end
  end

  // R9
  pirq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !p_en |=> !$rose(p_flag));
  // R10
  pflag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[0] && !p_hit) |=> !p_flag);
  // R10
  aflag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[1] && !a_hit) |=> !a_flag);
  // R7
  alarm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sel == AS_NONE) |=> !$rose(a_flag));
endmodule

// File: rtl/cal_clock_timer.sv
module cal_clock_timer
  import ctmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_256hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              periodic_irq,
  output logic              alarm_irq
);
  logic                run_q, pen_q, aen_q;
  psel_e               psel_q;
  asel_e               asel_q;
  logic [MIN_W-1:0]    cmp_min_q;
  logic [HOUR_W-1:0]   cmp_hour_q;
  logic [DAYCMP_W-1:0] cmp_day_q;

  logic wr_ctrl, wr_cfg, wr_stat, wr_sec, wr_min, wr_hour, wr_dlo, wr_dhi;
  logic wr_cmin, wr_chour, wr_cday;

  assign wr_ctrl  = bus_we && bus_addr == A_CTRL;
  assign wr_cfg   = bus_we && bus_addr == A_CFG;
  assign wr_stat  = bus_we && bus_addr == A_STAT;
  assign wr_sec   = bus_we && bus_addr == A_SEC;
  assign wr_min   = bus_we && bus_addr == A_MIN;
  assign wr_hour  = bus_we && bus_addr == A_HOUR;
  assign wr_dlo   = bus_we && bus_addr == A_DLO;
  assign wr_dhi   = bus_we && bus_addr == A_DHI;
  assign wr_cmin  = bus_we && bus_addr == A_CMIN;
  assign wr_chour = bus_we && bus_addr == A_CHOUR;
  assign wr_cday  = bus_we && bus_addr == A_CDAY;

  // registers left without reset
  always_ff @(posedge clk) begin
    if (wr_ctrl)  run_q <= bus_wdata[0];
    if (wr_cfg) begin
      psel_q <= psel_e'(bus_wdata[2:0]);
      asel_q <= asel_e'(bus_wdata[4:3]);
    end
    if (wr_cmin)  cmp_min_q  <= bus_wdata[MIN_W-1:0];
    if (wr_chour) cmp_hour_q <= bus_wdata[HOUR_W-1:0];
    if (wr_cday)  cmp_day_q  <= bus_wdata[DAYCMP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_q <= 1'b0;
      aen_q <= 1'b0;
    end else if (wr_cfg) begin
      pen_q <= bus_wdata[5];
      aen_q <= bus_wdata[6];
    end
  end

  logic [DIV_W-1:0]  div_cnt, div_fall;
  logic              div_carry, sec_carry, min_carry, hour_carry, day_carry;
  logic [SEC_W-1:0]  sec;
  logic [MIN_W-1:0]  minute;
  logic [HOUR_W-1:0] hour;
  logic [DAY_W-1:0]  day, day_ld_val;

  ctmr_prescaler #(.W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .adv(tick_256hz & run_q),
    .cnt(div_cnt), .fall(div_fall), .carry(div_carry)
  );

  ctmr_unit_cnt #(.W(SEC_W), .LAST(6'd59), .HAS_RST(1'b1)) u_sec (
    .clk(clk), .rst_n(rst_n), .adv(div_carry), .ld(1'b0), .ld_val('0),
    .val(sec), .carry(sec_carry)
  );

  ctmr_unit_cnt #(.W(MIN_W), .LAST(6'd59), .HAS_RST(1'b0)) u_min (
    .clk(clk), .rst_n(rst_n), .adv(sec_carry), .ld(wr_min),
    .ld_val(bus_wdata[MIN_W-1:0]), .val(minute), .carry(min_carry)
  );

  ctmr_unit_cnt #(.W(HOUR_W), .LAST(5'd23), .HAS_RST(1'b0)) u_hour (
    .clk(clk), .rst_n(rst_n), .adv(min_carry), .ld(wr_hour),
    .ld_val(bus_wdata[HOUR_W-1:0]), .val(hour), .carry(hour_carry)
  );

  assign day_ld_val = wr_dhi ? {bus_wdata, day[7:0]} : {day[15:8], bus_wdata};

  ctmr_unit_cnt #(.W(DAY_W), .LAST('1), .HAS_RST(1'b0)) u_day (
    .clk(clk), .rst_n(rst_n), .adv(hour_carry), .ld(wr_dlo | wr_dhi),
    .ld_val(day_ld_val), .val(day), .carry(day_carry)
  );

  ctmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .p_sel(psel_q), .a_sel(asel_q),
    .p_en(pen_q), .a_en(aen_q), .tap_fall(div_fall),
    .min_evt(sec_carry), .hour_evt(min_carry), .day_evt(hour_carry),
    .cur_min(minute), .cur_hour(hour), .cur_day(day[DAYCMP_W-1:0]),
    .cmp_min(cmp_min_q), .cmp_hour(cmp_hour_q), .cmp_day(cmp_day_q),
    .clr({2{wr_stat}} & bus_wdata[1:0]),
    .p_flag(periodic_irq), .a_flag(alarm_irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[0] = run_q;
      A_CFG:   bus_rdata[6:0] = {aen_q, pen_q, asel_q, psel_q};
      A_STAT:  bus_rdata[1:0] = {alarm_irq, periodic_irq};
      A_DIV:   bus_rdata = div_cnt;
      A_SEC:   bus_rdata[SEC_W-1:0] = sec;
      A_MIN:   bus_rdata[MIN_W-1:0] = minute;
      A_HOUR:  bus_rdata[HOUR_W-1:0] = hour;
      A_DLO:   bus_rdata = day[7:0];
      A_DHI:   bus_rdata = day[15:8];
      A_CMIN:  bus_rdata[MIN_W-1:0] = cmp_min_q;
      A_CHOUR: bus_rdata[HOUR_W-1:0] = cmp_hour_q;
      A_CDAY:  bus_rdata[DAYCMP_W-1:0] = cmp_day_q;
      default: bus_rdata = '0;
    endcase
  end

  // R3
  day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |=> day == '0);
  // R4
  sec_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sec && !div_carry) |=> $stable(sec));
endmodule

// File: tb/cal_clock_timer_bench.sv
module cal_clock_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_256hz = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       periodic_irq, alarm_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_clock_timer u_cal_clock_timer (
    .clk(clk), .rst_n(rst_n), .tick_256hz(tick_256hz),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .periodic_irq(periodic_irq), .alarm_irq(alarm_irq)
  );

  // {addr, write data, expected read-back}
  localparam logic [23:0] VEC [15] = '{
    {8'h05, 8'h2A, 8'h2A}, {8'h05, 8'hFF, 8'h3F}, {8'h06, 8'hFF, 8'h1F},
    {8'h06, 8'h15, 8'h15}, {8'h07, 8'hA5, 8'hA5}, {8'h08, 8'h3C, 8'h3C},
    {8'h04, 8'h25, 8'h00}, {8'h03, 8'h77, 8'h00}, {8'h09, 8'hFF, 8'h3F},
    {8'h0A, 8'hFF, 8'h1F}, {8'h0B, 8'hFF, 8'h1F}, {8'h00, 8'hFF, 8'h01},
    {8'h00, 8'h00, 8'h00}, {8'h01, 8'hFF, 8'h7F}, {8'h01, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk);
    bus_addr = a;
    #1 d = int'(bus_rdata);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_256hz = 1'b1;
    repeat (n) @(negedge clk);
    tick_256hz = 1'b0;
  endtask

  task automatic period_chk(input logic [2:0] sel, input int mask, input string req);
    int d, k;
    wr(4'h1, 8'h20 | 8'(sel));
    wr(4'h2, 8'h03);
    rd(4'h3, d);
    k = ((mask - (d & mask)) & mask) + 1;
    if (k > 1) ticks(k - 1);
    chk(req, int'(periodic_irq), 0);
    ticks(1);
    chk(req, int'(periodic_irq), 1);
  endtask

  // ticks needed from the current state until seconds roll 59 -> 0
  task automatic ticks_to_minute(output int n);
    int s, d;
    rd(4'h4, s);
    rd(4'h3, d);
    n = (59 - s) * 256 + (256 - d);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int v, n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    chk("R12 periodic_irq", int'(periodic_irq), 0);
    chk("R12 alarm_irq", int'(alarm_irq), 0);
    rd(4'h3, v); chk("R12 prescaler", v, 0);
    rd(4'h4, v); chk("R12 seconds", v, 0);
    rd(4'h2, v); chk("R12 status", v, 0);

    wr(4'h0, 8'h00);
    wr(4'h1, 8'h00);

    // R4 R5 R6 register table
    for (int i = 0; i < 15; i++) begin
      wr(VEC[i][19:16], VEC[i][15:8]);
      rd(VEC[i][19:16], v);
      chk("R4/R5/R6 table", v, int'(VEC[i][7:0]));
    end
    wr(4'h2, 8'h03);

    // R1 R2 run, stop, resume
    wr(4'h0, 8'h01);
    ticks(300);
    rd(4'h3, v); chk("R2 prescaler after 300", v, 44);
    rd(4'h4, v); chk("R2 seconds after 300", v, 1);
    wr(4'h0, 8'h00);
    ticks(50);
    rd(4'h3, v); chk("R1 prescaler held", v, 44);
    rd(4'h4, v); chk("R1 seconds held", v, 1);
    wr(4'h0, 8'h01);
    ticks(10);
    rd(4'h3, v); chk("R1 resumed", v, 54);

    // R8 prescaler taps
    period_chk(3'b000, 7,   "R8 32Hz");
    period_chk(3'b001, 31,  "R8 8Hz");
    period_chk(3'b010, 127, "R8 2Hz");
    period_chk(3'b011, 255, "R8 1Hz");

    // R9 disabled periodic
    wr(4'h1, 8'h00);
    wr(4'h2, 8'h03);
    ticks(16);
    chk("R9 periodic_irq disabled", int'(periodic_irq), 0);
    rd(4'h2, v); chk("R9 status disabled", v, 0);

    // R10 write-1-to-clear per bit
    wr(4'h1, 8'h20);
    ticks(8);
    wr(4'h2, 8'h02);
    chk("R10 other bit keeps flag", int'(periodic_irq), 1);
    wr(4'h2, 8'h01);
    chk("R10 cleared", int'(periodic_irq), 0);

    // R7 minute alarm, single firing
    wr(4'h1, 8'h4F);
    wr(4'h9, 8'h10);
    wr(4'h5, 8'h11);
    wr(4'h2, 8'h03);
    wr(4'h5, 8'h10);
    @(negedge clk);
    chk("R7 minute alarm", int'(alarm_irq), 1);
    wr(4'h2, 8'h02);
    repeat (3) @(negedge clk);
    chk("R7 fires once", int'(alarm_irq), 0);
    // R7 select none
    wr(4'h1, 8'h47);
    wr(4'h5, 8'h11);
    wr(4'h2, 8'h03);
    wr(4'h5, 8'h10);
    repeat (2) @(negedge clk);
    chk("R7 select none", int'(alarm_irq), 0);

    // R6 day compare uses 5 low bits
    wr(4'h1, 8'h5F);
    wr(4'h7, 8'h20);
    wr(4'h8, 8'h01);
    wr(4'h6, 8'h03);
    wr(4'hA, 8'h03);
    wr(4'hB, 8'h05);
    wr(4'h2, 8'h03);
    chk("R6 no match yet", int'(alarm_irq), 0);
    wr(4'h7, 8'h25);
    @(negedge clk);
    chk("R6 day low bits match", int'(alarm_irq), 1);
    wr(4'h1, 8'h07);
    wr(4'h2, 8'h03);

    // R3 R8 minute rollover, hour carry
    wr(4'h1, 8'h24);
    wr(4'h5, 8'd59);
    wr(4'h6, 8'd5);
    wr(4'h2, 8'h03);
    ticks_to_minute(n);
    if (n > 1) ticks(n - 1);
    chk("R8 minute event not early", int'(periodic_irq), 0);
    ticks(1);
    chk("R8 minute event", int'(periodic_irq), 1);
    rd(4'h4, v); chk("R3 seconds wrapped", v, 0);
    rd(4'h3, v); chk("R2 prescaler wrapped", v, 0);
    rd(4'h5, v); chk("R3 minutes wrapped", v, 0);
    rd(4'h6, v); chk("R3 hour carried", v, 6);

    // R3 R7 R8 day rollover and full alarm
    wr(4'h1, 8'h7E);
    wr(4'h6, 8'd23);
    wr(4'h5, 8'd59);
    wr(4'h7, 8'hFF);
    wr(4'h8, 8'hFF);
    wr(4'h9, 8'h00);
    wr(4'hA, 8'h00);
    wr(4'hB, 8'h00);
    wr(4'h2, 8'h03);
    ticks_to_minute(n);
    if (n > 1) ticks(n - 1);
    chk("R8 day event not early", int'(periodic_irq), 0);
    chk("R7 alarm not early", int'(alarm_irq), 0);
    ticks(1);
    chk("R8 day event", int'(periodic_irq), 1);
    @(negedge clk);
    chk("R7 full alarm", int'(alarm_irq), 1);
    rd(4'h6, v); chk("R3 hours wrapped", v, 0);
    rd(4'h7, v); chk("R3 day low wrapped", v, 0);
    rd(4'h8, v); chk("R3 day high wrapped", v, 0);

    // R11 write wins over carry
    wr(4'h1, 8'h07);
    wr(4'h2, 8'h03);
    wr(4'h5, 8'd59);
    wr(4'h6, 8'd8);
    ticks_to_minute(n);
    if (n > 1) ticks(n - 1);
    @(negedge clk);
    tick_256hz = 1'b1; bus_addr = 4'h5; bus_wdata = 8'h07; bus_we = 1'b1;
    @(negedge clk);
    tick_256hz = 1'b0; bus_we = 1'b0;
    rd(4'h5, v); chk("R11 written minute", v, 7);
    rd(4'h6, v); chk("R11 carry dropped", v, 8);
    rd(4'h4, v); chk("R11 seconds undisturbed", v, 0);
    rd(4'h3, v); chk("R11 prescaler undisturbed", v, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule